// File: doc/BRIEF.md
# Priority-Grouped Exception Arbiter

This block chooses which exception should go to the processor core next. It watches a table of exception vectors. Each vector has an enable flag, a pending flag, an active flag and a priority. A smaller priority value means a more urgent exception. From this table the block finds the most urgent vector that is both enabled and pending. It also finds the most urgent active handler and reduces that handler's priority to its group part. A programmable split divides each 8-bit priority into group bits and subpriority bits.

The block then works out the core's execution priority. It uses three inputs for this: a fault mask, a global mask and a base-priority threshold, each combined with the active group priority. From these it produces two outputs. The first is a take decision that includes the masks. The second is a raw request toward the core that ignores the masks. All outputs are registered and are computed again on every clock.

Priorities are 10-bit signed values. Vectors 1, 2 and 3 have fixed priorities of -3, -2 and -1. Vectors 4 and above take their 8-bit priority from the input bus. The idle value 0x100 (256) is one above the largest programmable priority, and it stands for "no exception".

Top module: `exc_prio_arbiter`

## Requirements
- R1: While rst_ni is low, the outputs are pend_vec_o = 0, pend_prio_o = 256, run_prio_o = 256, take_o = 0 and req_o = 0.
- R2: pend_vec_o is the lowest-numbered vector among the enabled and pending vectors (numbers 1 to NUM_VEC-1) with the strictly smallest effective priority. pend_prio_o is that vector's effective priority. When no vector is both enabled and pending, pend_vec_o = 0 and pend_prio_o = 256.
- R3: Vectors 1, 2 and 3 have effective priorities of -3, -2 and -1. For each vector n of 4 or more, the effective priority is the unsigned value of vec_prio_i[n*8 +: 8].
- R4: The active group priority is the smallest effective priority among the active vectors. If that value is non-negative, its low grp_i+1 bits are cleared; a negative value is left as it is. When no vector is active, the active group priority is 256.
- R5: run_prio_o is the smaller of the active group priority and a mask priority. The mask priority is found by the first of these rules that applies, in this order:
  - if fault_mask_i is 1, the mask priority is -1;
  - otherwise, if glob_mask_i is 1, it is 0;
  - otherwise, if base_prio_i is nonzero, it is base_prio_i with its low grp_i+1 bits cleared;
  - otherwise it is 256.
- R6: take_o is 1 exactly when run_prio_o is greater than pend_prio_o, comparing them as signed values.
- R7: req_o is 1 exactly when pend_prio_o is less than the active group priority, comparing them as signed values. fault_mask_i, glob_mask_i and base_prio_i have no effect on req_o.
- R8: Each output shows the inputs sampled at the previous rising clock edge. A change to an input between edges does not reach any output before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vec_en_i | input | NUM_VEC-1 | Enable flags; bit n belongs to vector n (vectors 1 to NUM_VEC-1) |
| vec_pend_i | input | NUM_VEC-1 | Pending flags; bit n belongs to vector n |
| vec_act_i | input | NUM_VEC-1 | Active flags; bit n belongs to vector n |
| vec_prio_i | input | (NUM_VEC-4)*8 | Programmable priorities; vector n uses bits [n*8 +: 8], for n = 4 to NUM_VEC-1 |
| grp_i | input | 3 | Group split: the low grp_i+1 bits of a priority are subpriority |
| fault_mask_i | input | 1 | Fault mask; raises the execution priority to -1 |
| glob_mask_i | input | 1 | Global mask; raises the execution priority to 0 |
| base_prio_i | input | 8 | Base-priority threshold; 0 means no threshold |
| pend_vec_o | output | clog2(NUM_VEC) | Number of the selected pending vector; 0 means none |
| pend_prio_o | output | 10 | Signed priority of the selected pending vector |
| run_prio_o | output | 10 | Signed execution priority |
| take_o | output | 1 | The pending exception may be taken now |
| req_o | output | 1 | Request toward the core; ignores the masks |

## Verification
The assertions assume that the priority inputs take only the values R3 defines. They also assume that every input stays stable for one full clock before the edge that samples it. The bench keeps to both assumptions: it drives all inputs on the falling edge and reads the outputs on the following falling edge.

The random stimulus keeps the pending and active flags sparse. Some of the time it draws priorities from a range of only four values, so that ties and subpriority-only differences occur often. Directed cases cover the following:
- fixed-priority vectors;
- a pending exception that differs from the active handler only in subpriority;
- the mask priority order in R5;
- the one-cycle latency in R8.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;
  localparam int PRIO_W    = 8;
  localparam int SP_W      = PRIO_W + 2;
  localparam int GRP_W     = $clog2(PRIO_W);
  localparam int NUM_FIXED = 4;

  typedef logic signed [SP_W-1:0] sprio_t;

  localparam sprio_t NOEXC = sprio_t'(1 << PRIO_W);

  // clear subpriority bits; negative fixed priorities carry none
  function automatic sprio_t grp_clip(sprio_t p, logic [GRP_W-1:0] g);
    logic [SP_W-1:0] m;
    m = {SP_W{1'b1}} << (g + 1);
    if (p < 0) return p;
    return sprio_t'(p & m);
  endfunction
endpackage

// File: rtl/exc_prio_map.sv
module exc_prio_map
  import exc_arb_pkg::*;
#(
  parameter int NUM_VEC = 48
) (
  input  logic [NUM_VEC*PRIO_W-1:NUM_FIXED*PRIO_W] prio_i,
  output sprio_t                                   eff_o [NUM_VEC-1:1]
);
  for (genvar g = 1; g < NUM_VEC; g++) begin : g_vec
    if (g < NUM_FIXED) begin : g_fixed
      assign eff_o[g] = sprio_t'(g - NUM_FIXED);
    end else begin : g_prog
      assign eff_o[g] = sprio_t'({2'b00, prio_i[g*PRIO_W +: PRIO_W]});
    end
  end
endmodule

// File: rtl/exc_pend_sel.sv
module exc_pend_sel
  import exc_arb_pkg::*;
#(
  parameter int NUM_VEC = 48,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:1] en_i,
  input  logic [NUM_VEC-1:1] pend_i,
  input  sprio_t             eff_i [NUM_VEC-1:1],
  output logic [VEC_W-1:0]   vec_o,
  output sprio_t             prio_o
);
  always_comb begin
    prio_o = NOEXC;
    vec_o  = '0;
    // ascending scan with strict compare keeps the lowest index on ties
    for (int i = 1; i < NUM_VEC; i++) begin
      if (en_i[i] && pend_i[i] && (eff_i[i] < prio_o)) begin
        prio_o = eff_i[i];
        vec_o  = VEC_W'(i);
      end
    end
  end
endmodule

// File: rtl/exc_act_grp.sv
module exc_act_grp
  import exc_arb_pkg::*;
#(
  parameter int NUM_VEC = 48
) (
  input  logic [NUM_VEC-1:1] act_i,
  input  sprio_t             eff_i [NUM_VEC-1:1],
  input  logic [GRP_W-1:0]   grp_i,
  output sprio_t             grp_prio_o
);
  sprio_t best;

  always_comb begin
    best = NOEXC;
    for (int i = 1; i < NUM_VEC; i++) begin
      if (act_i[i] && (eff_i[i] < best)) best = eff_i[i];
    end
  end

  assign grp_prio_o = grp_clip(best, grp_i);
endmodule

// File: rtl/exc_exec_prio.sv
module exc_exec_prio
  import exc_arb_pkg::*;
(
  input  logic              fault_mask_i,
  input  logic              glob_mask_i,
  input  logic [PRIO_W-1:0] base_prio_i,
  input  logic [GRP_W-1:0]  grp_i,
  input  sprio_t            act_grp_i,
  output sprio_t            run_o
);
  sprio_t mask_prio;

  always_comb begin
    if (fault_mask_i)             mask_prio = sprio_t'(-1);
    else if (glob_mask_i)         mask_prio = '0;
    else if (base_prio_i != '0)   mask_prio = grp_clip(sprio_t'({2'b00, base_prio_i}), grp_i);
    else                          mask_prio = NOEXC;
  end

  assign run_o = (mask_prio < act_grp_i) ? mask_prio : act_grp_i;
endmodule

// File: rtl/exc_prio_arbiter.sv
module exc_prio_arbiter
  import exc_arb_pkg::*;
#(
  parameter int NUM_VEC = 48,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic [NUM_VEC-1:1]                     vec_en_i,
  input  logic [NUM_VEC-1:1]                     vec_pend_i,
  input  logic [NUM_VEC-1:1]                     vec_act_i,
  input  logic [NUM_VEC*PRIO_W-1:NUM_FIXED*PRIO_W] vec_prio_i,
  input  logic [GRP_W-1:0]                       grp_i,
  input  logic                                   fault_mask_i,
  input  logic                                   glob_mask_i,
  input  logic [PRIO_W-1:0]                      base_prio_i,
  output logic [VEC_W-1:0]                       pend_vec_o,
  output logic signed [SP_W-1:0]                 pend_prio_o,
  output logic signed [SP_W-1:0]                 run_prio_o,
  output logic                                   take_o,
  output logic                                   req_o
);
  sprio_t           eff [NUM_VEC-1:1];
  logic [VEC_W-1:0] pend_vec_d;
  sprio_t           pend_prio_d;
  sprio_t           act_grp_d;
  sprio_t           run_d;

  exc_prio_map #(.NUM_VEC(NUM_VEC)) u_map (
    .prio_i (vec_prio_i),
    .eff_o  (eff)
  );

  exc_pend_sel #(.NUM_VEC(NUM_VEC)) u_pend (
    .en_i   (vec_en_i),
    .pend_i (vec_pend_i),
    .eff_i  (eff),
    .vec_o  (pend_vec_d),
    .prio_o (pend_prio_d)
  );

  exc_act_grp #(.NUM_VEC(NUM_VEC)) u_act (
    .act_i      (vec_act_i),
    .eff_i      (eff),
    .grp_i      (grp_i),
    .grp_prio_o (act_grp_d)
  );

  exc_exec_prio u_exec (
    .fault_mask_i (fault_mask_i),
    .glob_mask_i  (glob_mask_i),
    .base_prio_i  (base_prio_i),
    .grp_i        (grp_i),
    .act_grp_i    (act_grp_d),
    .run_o        (run_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vec_o  <= '0;
      pend_prio_o <= NOEXC;
      run_prio_o  <= NOEXC;
      take_o      <= 1'b0;
      req_o       <= 1'b0;
    end else begin
      pend_vec_o  <= pend_vec_d;
      pend_prio_o <= pend_prio_d;
      run_prio_o  <= run_d;
      take_o      <= run_d > pend_prio_d;
      req_o       <= pend_prio_d < act_grp_d;
    end
  end

  a_r2_idle_prio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_vec_o == '0) |-> (pend_prio_o == NOEXC));

  a_r3_nmi_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_vec_o == VEC_W'(2)) |-> (pend_prio_o == sprio_t'(-2)));

  a_r5_fault_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(fault_mask_i)) |-> (run_prio_o <= sprio_t'(-1)));

  a_r5_glob_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(glob_mask_i)) |-> (run_prio_o <= sprio_t'(0)));

  a_r6_take_rel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o == (run_prio_o > pend_prio_o));

  a_r7_req_needs_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (pend_vec_o != '0));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $stable(vec_en_i) && $stable(vec_pend_i) && $stable(vec_act_i) &&
     $stable(vec_prio_i) && $stable(grp_i) && $stable(fault_mask_i) &&
     $stable(glob_mask_i) && $stable(base_prio_i))
    |=> ($stable(pend_vec_o) && $stable(run_prio_o) && $stable(req_o)));
endmodule

// File: tb/exc_prio_arbiter_tb.sv
module exc_prio_arbiter_tb_top;
  localparam int CLK_P = 10;
  localparam int NV    = 48;
  localparam int VW    = $clog2(NV);

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NV-1:1]        en_v = '0, pd_v = '0, ac_v = '0;
  logic [NV*8-1:32]     pr_v = '0;
  logic [2:0]           grp = '0;
  logic                 fmask = 1'b0, gmask = 1'b0;
  logic [7:0]           base = '0;
  logic [VW-1:0]        pend_vec;
  logic signed [9:0]    pend_prio, run_prio;
  logic                 take, req;

  bit en[NV], pd[NV], ac[NV];
  int pr[NV];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  exc_prio_arbiter #(.NUM_VEC(NV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .vec_en_i(en_v), .vec_pend_i(pd_v), .vec_act_i(ac_v),
    .vec_prio_i(pr_v), .grp_i(grp), .fault_mask_i(fmask), .glob_mask_i(gmask),
    .base_prio_i(base), .pend_vec_o(pend_vec), .pend_prio_o(pend_prio),
    .run_prio_o(run_prio), .take_o(take), .req_o(req));

  function automatic int eff(int i);
    if (i < 4) return i - 4;
    return pr[i];
  endfunction

  function automatic int clip(int p, int g);
    if (p < 0) return p;
    return p & ~((1 << (g + 1)) - 1);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_tab();
    for (int i = 0; i < NV; i++) begin en[i] = 0; pd[i] = 0; ac[i] = 0; pr[i] = 0; end
    grp = 0; fmask = 0; gmask = 0; base = 0;
  endtask

  task automatic drive();
    for (int i = 1; i < NV; i++) begin
      en_v[i] = en[i]; pd_v[i] = pd[i]; ac_v[i] = ac[i];
      if (i >= 4) pr_v[i*8 +: 8] = 8'(pr[i]);
    end
  endtask

  // drive at falling edge, check one full cycle later (R8)
  task automatic apply();
    int best, bidx, actp, m, run;
    @(negedge clk);
    drive();
    best = 256; bidx = 0; actp = 256;
    for (int i = 1; i < NV; i++) begin
      if (en[i] && pd[i] && eff(i) < best) begin best = eff(i); bidx = i; end
      if (ac[i] && eff(i) < actp) actp = eff(i);
    end
    actp = clip(actp, int'(grp));
    if (fmask) m = -1;
    else if (gmask) m = 0;
    else if (base != 0) m = clip(int'(base), int'(grp));
    else m = 256;
    run = (m < actp) ? m : actp;
    @(negedge clk);
    chk("R2 pend_vec", int'(pend_vec), bidx);
    chk("R2 R3 pend_prio", int'(pend_prio), best);
    chk("R4 R5 run_prio", int'(run_prio), run);
    chk("R6 take", int'(take), int'(run > best));
    chk("R7 req", int'(req), int'(best < actp));
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    clear_tab();
    drive();
    #(CLK_P * 2 + 2);
    // R1 reset state
    chk("R1 pend_vec", int'(pend_vec), 0);
    chk("R1 pend_prio", int'(pend_prio), 256);
    chk("R1 run_prio", int'(run_prio), 256);
    chk("R1 take", int'(take), 0);
    chk("R1 req", int'(req), 0);
    @(negedge clk); rst_n = 1'b1;

    apply();                                         // idle
    clear_tab(); en[20] = 1; pd[20] = 1; pr[20] = 5;
    en[10] = 1; pd[10] = 1; pr[10] = 5; apply();     // R2 tie -> 10
    clear_tab(); en[11] = 1; pr[11] = 1; pd[12] = 1; pr[12] = 1; apply(); // R2 none
    clear_tab(); for (int i = 1; i < 6; i++) begin en[i] = 1; pd[i] = 1; end apply(); // R3 -> 1
    clear_tab(); en[2] = 1; pd[2] = 1; en[3] = 1; pd[3] = 1; apply();  // R3 NMI -2
    clear_tab(); en[3] = 1; pd[3] = 1; en[4] = 1; pd[4] = 1; pr[4] = 0; apply(); // R3 -1 beats 0
    // R4 subpriority does not preempt: active 0x37, g=2 -> 0x30
    clear_tab(); grp = 2; ac[20] = 1; pr[20] = 'h37;
    en[30] = 1; pd[30] = 1; pr[30] = 'h31; apply();
    pr[30] = 'h2f; apply();
    // R5 base priority threshold
    clear_tab(); grp = 3; base = 'h45; en[9] = 1; pd[9] = 1; pr[9] = 'h40; apply();
    pr[9] = 'h3f; apply();
    // R5 global mask, R7 req ignores masks
    clear_tab(); gmask = 1; base = 'h80; en[9] = 1; pd[9] = 1; pr[9] = 0; apply();
    // R5 fault mask allows NMI only
    clear_tab(); fmask = 1; gmask = 1; en[2] = 1; pd[2] = 1; en[5] = 1; pd[5] = 1; apply();
    clear_tab(); fmask = 1; en[5] = 1; pd[5] = 1; pr[5] = 0; apply();
    // R4 active hard fault is negative and not clipped
    clear_tab(); grp = 7; ac[3] = 1; ac[8] = 1; pr[8] = 3; en[2] = 1; pd[2] = 1; apply();
    clear_tab(); grp = 7; ac[8] = 1; pr[8] = 'hff; en[9] = 1; pd[9] = 1; pr[9] = 'h7f; apply();

    // R8 latency: a change before the edge is not visible
    clear_tab(); apply();
    @(negedge clk);
    en[7] = 1; pd[7] = 1; pr[7] = 2; drive();
    #(CLK_P/4);
    chk("R8 pend_vec held", int'(pend_vec), 0);
    @(negedge clk);
    chk("R8 pend_vec updated", int'(pend_vec), 7);

    for (int n = 0; n < 400; n++) begin
      bit narrow;
      narrow = ($urandom % 2) == 0;
      for (int i = 0; i < NV; i++) begin
        en[i] = ($urandom % 2) == 0;
        pd[i] = ($urandom % 6) == 0;
        ac[i] = ($urandom % 12) == 0;
        pr[i] = narrow ? int'($urandom % 4) * 3 + 16 : int'($urandom % 256);
      end
      grp   = 3'($urandom % 8);
      fmask = ($urandom % 8) == 0;
      gmask = ($urandom % 8) == 0;
      base  = (($urandom % 2) == 0) ? 8'h00 : 8'($urandom);
      apply();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule